// File: doc/BRIEF.md
# Modem-Line Edge Interrupt Unit

This block sits beside a serial port's data path and owns its modem-control lines. Two outputs, the terminal-ready and request-to-send lines, are driven from control bits. Each output is the inverse of the bit behind it, so writing a 1 releases the line. Four inputs are brought into the clock domain through a synchronizer chain: ring indicator, clear-to-send, carrier detect and data-set-ready. Software reads their present levels from a single status register.

Only the clear-to-send and carrier-detect inputs can raise edge events. By default a line latches an event when it becomes asserted. A per-line "any edge" option makes a release count as well. Latched events stay pending until software reads the status register. Each of the two lines has its own enable. Their combined request passes through one further enable, which stands for this source's bit in the port's top-level interrupt mask, before it reaches `irq_o`.

Access is through a plain single-cycle register port. A write is accepted on the clock edge where `reg_wr_i` is high. A read on the edge where `reg_rd_i` is high returns its data on `reg_rdata_o` after that edge, and that data is held until the next read. There is no back-pressure: every access completes in one cycle.

Top module: `mdm_edge_irq`

## Requirements
- R1: After reset the two control bits are 1, so `dtr_o` and `rts_o` are 0. All enables and any-edge options are 0, no event is pending and `irq_o` is 0.
- R2: Register 0 holds the control bits: bit 0 for the terminal-ready line and bit 1 for request-to-send. From the cycle after a write, `dtr_o` equals the inverse of bit 0 and `rts_o` equals the inverse of bit 1.
- R3: Register 3 (line status) reports the synchronized input levels: bit 0 ring indicator, bit 1 clear-to-send, bit 2 carrier detect, bit 3 data-set-ready. A pin change becomes visible in a read issued two or more cycles later.
- R4: Register 1 is the edge configuration: bit 0 clear-to-send enable, bit 1 carrier-detect enable, bit 2 clear-to-send any-edge, bit 3 carrier-detect any-edge. With a line's any-edge bit at 0, only a 0-to-1 change of that line sets its event bit, and a 1-to-0 change leaves it clear.
- R5: With a line's any-edge bit at 1, both rising and falling changes set its event bit.
- R6: Line status bit 4 is the clear-to-send event and bit 5 is the carrier-detect event. Reading register 3 returns the events and clears them. Reading any other register leaves them pending.
- R7: An event is latched whatever its enable. `irq_o` counts only the events whose line enable is 1.
- R8: Register 2 bit 0 is the top-level enable for this source. `irq_o` is 1 only when that bit is 1 and an enabled event is pending.
- R9: An event detected in the same cycle as a status read is not lost. That read returns the bit as 0, and the event stays pending for the next read.
- R10: Changes on the ring-indicator and data-set-ready inputs never set event bits or raise `irq_o`.
- R11: Registers 0, 1 and 2 read back the value last written, zero-extended to 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_addr_i | input | 2 | Register select (0 control, 1 edge config, 2 top enable, 3 line status) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, registered, held between reads |
| ri_i | input | 1 | Ring indicator input, asynchronous |
| cts_i | input | 1 | Clear-to-send input, asynchronous |
| dcd_i | input | 1 | Carrier-detect input, asynchronous |
| dsr_i | input | 1 | Data-set-ready input, asynchronous |
| dtr_o | output | 1 | Terminal-ready output, inverse of control bit 0 |
| rts_o | output | 1 | Request-to-send output, inverse of control bit 1 |
| irq_o | output | 1 | Interrupt request after line and top-level enables |

## Verification
A status read clears the event bits, and a newly detected edge sets them. Both can land on the same clock edge. The bench provokes this by changing clear-to-send and timing a read so that its capture edge is the edge on which the detector fires. The read itself must return the event bit as 0, `irq_o` must be high right after it, and a second read must return the event bit as 1. Two read-after-clear steps and a rise-only filter also fall in the same cycle when the line is released. The bench checks that case as a falling change with any-edge off, which must leave the event bit clear.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  localparam int REG_W     = 8;
  localparam int ADDR_W    = 2;
  localparam int NUM_LINES = 4;
  localparam int NUM_EDGE  = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_MCTL  = 2'd0,
    ADR_ECFG  = 2'd1,
    ADR_TMASK = 2'd2,
    ADR_LSTAT = 2'd3
  } reg_addr_e;

  // Bit position of each input within the synchronized level vector
  localparam int LN_RI  = 0;
  localparam int LN_CTS = 1;
  localparam int LN_DCD = 2;
  localparam int LN_DSR = 3;

  // Edge-capable lines, in order of their event bits
  localparam int EDGE_SRC [NUM_EDGE] = '{LN_CTS, LN_DCD};

  typedef struct packed {
    logic [NUM_EDGE-1:0] any_edge;
    logic [NUM_EDGE-1:0] line_en;
  } edge_cfg_t;

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/mdm_edge_cell.sv
module mdm_edge_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic any_edge_i,
  input  logic clear_i,
  output logic pend_o
);

  logic prev_q;
  logic pend_q;
  logic rise, fall, hit;

  assign rise = level_i & ~prev_q;
  assign fall = ~level_i & prev_q;
  assign hit  = rise | (any_edge_i & fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= level_i;
      pend_q <= (pend_q & ~clear_i) | hit;
    end
  end

  assign pend_o = pend_q;

  // R6: a clear with no new event empties the bit
  p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !hit) |=> !pend_o);

  // R9: a detected event is pending after the edge, even during a clear
  p_event_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend_o);

  // R4: in rise-only mode a new event follows an asserted level
  p_rise_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pend_o) && !$past(any_edge_i)) |-> $past(level_i));

  // R6: without clear or event the bit holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !hit) |=> $stable(pend_o));

endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
  import mdm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic [NUM_LINES-1:0] level_i,
  input  logic [NUM_EDGE-1:0]  pend_i,
  output logic [1:0]           mctl_o,
  output edge_cfg_t            ecfg_o,
  output logic                 top_en_o,
  output logic                 stat_clear_o,
  output logic [REG_W-1:0]     rdata_o
);

  localparam int ECFG_W = 2 * NUM_EDGE;
  localparam int STAT_W = NUM_LINES + NUM_EDGE;

  logic [1:0]       mctl_q;
  edge_cfg_t        ecfg_q;
  logic             top_q;
  logic [REG_W-1:0] rdata_q;
  logic [REG_W-1:0] rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mctl_q <= 2'b11;
      ecfg_q <= '0;
      top_q  <= 1'b0;
    end else if (wr_i) begin
      unique case (reg_addr_e'(addr_i))
        ADR_MCTL:  mctl_q <= wdata_i[1:0];
        ADR_ECFG:  ecfg_q <= edge_cfg_t'(wdata_i[ECFG_W-1:0]);
        ADR_TMASK: top_q  <= wdata_i[0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr_e'(addr_i))
      ADR_MCTL:  rd_mux[1:0]        = mctl_q;
      ADR_ECFG:  rd_mux[ECFG_W-1:0] = ecfg_q;
      ADR_TMASK: rd_mux[0]          = top_q;
      default:   rd_mux[STAT_W-1:0] = {pend_i, level_i};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign stat_clear_o = rd_i && (reg_addr_e'(addr_i) == ADR_LSTAT);
  assign mctl_o       = mctl_q;
  assign ecfg_o       = ecfg_q;
  assign top_en_o     = top_q;
  assign rdata_o      = rdata_q;

  // R11: a configuration write is reflected by the next read of that register
  p_ecfg_written_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && reg_addr_e'(addr_i) == ADR_ECFG) |=> (ecfg_o == $past(wdata_i[ECFG_W-1:0])));

endmodule

// File: rtl/mdm_edge_irq.sv
module mdm_edge_irq
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              ri_i,
  input  logic              cts_i,
  input  logic              dcd_i,
  input  logic              dsr_i,
  output logic              dtr_o,
  output logic              rts_o,
  output logic              irq_o
);

  logic [NUM_LINES-1:0] pins_raw;
  logic [NUM_LINES-1:0] level_s;
  logic [NUM_EDGE-1:0]  pend;
  logic [1:0]           mctl;
  edge_cfg_t            ecfg;
  logic                 top_en;
  logic                 stat_clear;
  logic                 src_req;

  always_comb begin
    pins_raw         = '0;
    pins_raw[LN_RI]  = ri_i;
    pins_raw[LN_CTS] = cts_i;
    pins_raw[LN_DCD] = dcd_i;
    pins_raw[LN_DSR] = dsr_i;
  end

  mdm_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pins_raw),
    .sync_o  (level_s)
  );

  generate
    for (genvar e = 0; e < NUM_EDGE; e++) begin : g_edge
      mdm_edge_cell u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_i    (level_s[EDGE_SRC[e]]),
        .any_edge_i (ecfg.any_edge[e]),
        .clear_i    (stat_clear),
        .pend_o     (pend[e])
      );
    end
  endgenerate

  mdm_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (reg_wr_i),
    .rd_i         (reg_rd_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .level_i      (level_s),
    .pend_i       (pend),
    .mctl_o       (mctl),
    .ecfg_o       (ecfg),
    .top_en_o     (top_en),
    .stat_clear_o (stat_clear),
    .rdata_o      (reg_rdata_o)
  );

  assign src_req = |(pend & ecfg.line_en);
  assign irq_o   = src_req & top_en;
  assign dtr_o   = ~mctl[0];
  assign rts_o   = ~mctl[1];

  // R2: pins carry the inverse of the control bits written
  p_out_inverted_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_e'(reg_addr_i) == ADR_MCTL)
      |=> (dtr_o == ~$past(reg_wdata_i[0]) && rts_o == ~$past(reg_wdata_i[1])));

  // R8: no request leaves while the top-level enable is off
  p_top_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> top_en);

  // R7: a request needs an enabled pending event
  p_line_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(pend & ecfg.line_en)));

endmodule

// File: tb/mdm_edge_irq_tb.sv
module mdm_edge_irq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic       reg_rd_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       ri_i = 1'b0, cts_i = 1'b0, dcd_i = 1'b0, dsr_i = 1'b0;
  logic       dtr_o, rts_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  mdm_edge_irq u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .ri_i(ri_i), .cts_i(cts_i), .dcd_i(dcd_i), .dsr_i(dsr_i),
    .dtr_o(dtr_o), .rts_o(rts_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_rd_i = 1'b1; reg_addr_i = a;
    @(negedge clk);
    reg_rd_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_events();
    logic [7:0] d;
    settle();
    rd(2'd3, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk(dtr_o == 1'b0 && rts_o == 1'b0, "R1 pins", {6'b0, rts_o, dtr_o}, 8'h00);
    chk(irq_o == 1'b0, "R1 irq", {7'b0, irq_o}, 8'h00);
    rd(2'd0, d); chk(d == 8'h03, "R1 control bits", d, 8'h03);
    rd(2'd1, d); chk(d == 8'h00, "R1 edge config", d, 8'h00);
    rd(2'd2, d); chk(d == 8'h00, "R1 top enable", d, 8'h00);
    rd(2'd3, d); chk(d == 8'h00, "R1 status", d, 8'h00);
  endtask

  task automatic t_outputs();
    logic [7:0] d;
    wr(2'd0, 8'h00);
    chk(dtr_o && rts_o, "R2 write 00", {6'b0, rts_o, dtr_o}, 8'h03);
    wr(2'd0, 8'h01);
    chk(!dtr_o && rts_o, "R2 write 01", {6'b0, rts_o, dtr_o}, 8'h02);
    wr(2'd0, 8'h02);
    chk(dtr_o && !rts_o, "R2 write 02", {6'b0, rts_o, dtr_o}, 8'h01);
    rd(2'd0, d); chk(d == 8'h02, "R11 control readback", d, 8'h02);
    wr(2'd1, 8'h0a);
    rd(2'd1, d); chk(d == 8'h0a, "R11 edge config readback", d, 8'h0a);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_levels();
    logic [7:0] d;
    ri_i = 1'b1; dsr_i = 1'b1;
    settle();
    rd(2'd3, d); chk(d == 8'h09, "R3 ri+dsr level", d, 8'h09);
    ri_i = 1'b0; dsr_i = 1'b0; cts_i = 1'b1; dcd_i = 1'b1;
    settle();
    rd(2'd3, d); chk(d[3:0] == 4'h6, "R3 cts+dcd level", {4'b0, d[3:0]}, 8'h06);
    cts_i = 1'b0; dcd_i = 1'b0;
    clear_events();
  endtask

  task automatic t_ri_dsr();
    logic [7:0] d;
    wr(2'd1, 8'h0f); wr(2'd2, 8'h01);
    ri_i = 1'b1; dsr_i = 1'b1; settle();
    ri_i = 1'b0; dsr_i = 1'b0; settle();
    chk(irq_o == 1'b0, "R10 irq", {7'b0, irq_o}, 8'h00);
    rd(2'd3, d); chk(d == 8'h00, "R10 no event", d, 8'h00);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_rise_only();
    logic [7:0] d;
    cts_i = 1'b1; settle();
    rd(2'd3, d); chk(d == 8'h12, "R4 cts rise sets", d, 8'h12);
    cts_i = 1'b0; settle();
    rd(2'd3, d); chk(d == 8'h00, "R4 cts fall ignored", d, 8'h00);
    dcd_i = 1'b1; settle(); dcd_i = 1'b0; settle();
    rd(2'd3, d); chk(d == 8'h20, "R4 dcd pulse once", d, 8'h20);
  endtask

  task automatic t_any_edge();
    logic [7:0] d;
    wr(2'd1, 8'h0c);
    cts_i = 1'b1; dcd_i = 1'b1; clear_events();
    cts_i = 1'b0; settle();
    rd(2'd3, d); chk(d == 8'h14, "R5 cts fall counts", d, 8'h14);
    dcd_i = 1'b0; settle();
    rd(2'd3, d); chk(d == 8'h20, "R5 dcd fall counts", d, 8'h20);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_read_clear();
    logic [7:0] d;
    cts_i = 1'b1; settle(); cts_i = 1'b0; settle();
    rd(2'd0, d); rd(2'd1, d); rd(2'd2, d);
    rd(2'd3, d); chk(d == 8'h10, "R6 survives other reads", d, 8'h10);
    rd(2'd3, d); chk(d == 8'h00, "R6 cleared by read", d, 8'h00);
  endtask

  task automatic t_line_enable();
    logic [7:0] d;
    wr(2'd2, 8'h01); wr(2'd1, 8'h02);
    cts_i = 1'b1; settle();
    chk(irq_o == 1'b0, "R7 disabled line no irq", {7'b0, irq_o}, 8'h00);
    rd(2'd3, d); chk(d == 8'h12, "R7 latched while disabled", d, 8'h12);
    dcd_i = 1'b1; settle();
    chk(irq_o == 1'b1, "R7 enabled line irq", {7'b0, irq_o}, 8'h01);
    rd(2'd3, d);
    chk(irq_o == 1'b0, "R7 irq drops after read", {7'b0, irq_o}, 8'h00);
    cts_i = 1'b0; dcd_i = 1'b0;
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    clear_events();
  endtask

  task automatic t_top_enable();
    logic [7:0] d;
    wr(2'd1, 8'h01);
    cts_i = 1'b1; settle();
    chk(irq_o == 1'b0, "R8 top off no irq", {7'b0, irq_o}, 8'h00);
    wr(2'd2, 8'h01);
    chk(irq_o == 1'b1, "R8 top on irq", {7'b0, irq_o}, 8'h01);
    wr(2'd2, 8'h00);
    chk(irq_o == 1'b0, "R8 top off again", {7'b0, irq_o}, 8'h00);
    cts_i = 1'b0;
    clear_events();
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    wr(2'd1, 8'h01); wr(2'd2, 8'h01);
    cts_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(2'd3, d);
    chk(d == 8'h02, "R9 read on event edge", d, 8'h02);
    chk(irq_o == 1'b1, "R9 irq after collided read", {7'b0, irq_o}, 8'h01);
    rd(2'd3, d);
    chk(d == 8'h12, "R9 event kept", d, 8'h12);
    cts_i = 1'b0;
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    clear_events();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_outputs();
    t_levels();
    t_ri_dsr();
    t_rise_only();
    t_any_edge();
    t_read_clear();
    t_line_enable();
    t_top_enable();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule